// File: doc/BRIEF.md
# DCT Block Spread-Spectrum Watermark Inserter

This block hides an invisible mark in an image that has already been transformed into 8x8 blocks of DCT coefficients. Coefficients of one block arrive one per cycle, in index order, with a start marker on index 0. While a block streams in, a selection stage keeps a running list of the three AC coefficients with the largest magnitude. The whole block is stored in one half of a two-bank buffer. When the last coefficient of the block has been taken in, an insertion stage replays the stored block. It scales each of the three chosen coefficients by one plus the strength factor times a pseudo-random value. Every other coefficient, including the DC term, passes through unchanged.

The pseudo-random values come from a 16-bit LFSR that is loaded from a seed input on reset. Embedding with the same seed therefore gives the same result again. The strength factor is an unsigned fraction with eight fractional bits. A new block may be fed in while the previous one is being replayed, so a continuous input stream gives a continuous output stream, delayed by one block.

Top module: `dct_mark_embed`

## Requirements
- R1: During and after reset, and until a block has been fully received, `coef_vld_o` and `blk_start_o` are 0 and `coef_o` is 0.
- R2: A cycle with `coef_vld_i`=1 and `blk_start_i`=1 starts a block at index 0. Each later cycle with `coef_vld_i`=1 takes the next index, and index 63 completes the block. A new start marker before index 63 discards the partial block. Valid coefficients outside a started block are ignored and produce no output.
- R3: The coefficient at index 0 (DC) is never modified.
- R4: Exactly the three AC coefficients (indices 1..63) with the largest magnitude are modified. The magnitude of -32768 is 32768. Among equal magnitudes, the lower index wins.
- R5: Coefficients that are not selected leave the block with the value they had on input.
- R6: A block is emitted in index order on 64 consecutive cycles, and `blk_start_o` is 1 only with index 0. `coef_vld_o` first rises on the cycle after the clock edge that accepts index 63.
- R7: A selected coefficient v becomes v + floor(v·a·x / 2^23), saturated to [-32768, 32767]. Here a is the value of `wm_alpha_i` at the edge that accepts index 63, and x is the LFSR value read as a signed 16-bit number.
- R8: The LFSR steps as s' = {s[14:0], s[15]^s[13]^s[12]^s[10]}. Reset loads it from `wm_seed_i`, and a seed of 0 is replaced by 1. In the b-th completed block since reset (b from 0), the selected coefficient of rank k (0 = largest) uses the state after 3b+k steps.
- R9: Blocks may be sent back to back without idle cycles, and their output then follows without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also reloads the LFSR from the seed |
| wm_seed_i | input | 16 | LFSR seed |
| wm_alpha_i | input | 8 | Strength factor, unsigned, 8 fractional bits |
| coef_vld_i | input | 1 | Input coefficient valid |
| blk_start_i | input | 1 | Marks index 0 of a block |
| coef_i | input | 16 | Input coefficient, signed |
| coef_vld_o | output | 1 | Output coefficient valid |
| blk_start_o | output | 1 | Marks index 0 of an output block |
| coef_o | output | 16 | Output coefficient, signed |

## Verification
The hazardous overlap is between the edge that accepts the last coefficient of block N+1 and the edge that emits the last coefficient of block N. On that edge the replay stage is loaded with a new bank, a new selection and a new strength value while it still produces its final output. The bench provokes this by sending three blocks back to back with different strengths and patterns. Each output is judged by a scoreboard that models selection, LFSR stepping and saturation, and the bench also checks that the valid output runs unbroken for all 192 cycles.

// File: rtl/dme_pkg.sv
package dme_pkg;
    parameter int COEF_W  = 16;
    parameter int ALPHA_W = 8;
    parameter int PRNG_W  = 16;
    parameter int BLK_LEN = 64;
    parameter int TOP_N   = 3;
    parameter int IDX_W   = $clog2(BLK_LEN);
    parameter int MAG_W   = COEF_W + 1;
    parameter int FRAC_W  = ALPHA_W + PRNG_W - 1;
    parameter int PROD_W  = COEF_W + ALPHA_W + PRNG_W + 2;
    parameter logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_LEN - 1);

    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic [IDX_W-1:0]         idx_t;
    typedef logic [MAG_W-1:0]         mag_t;
    typedef logic [PRNG_W-1:0]        prng_t;
    typedef logic [ALPHA_W-1:0]       alpha_t;

    // One entry of the running largest-magnitude list
    typedef struct packed {
        logic vld;
        mag_t mag;
        idx_t idx;
    } slot_t;

    // One coefficient chosen for marking, with its watermark value
    typedef struct packed {
        idx_t  idx;
        prng_t x;
    } mark_t;

    function automatic mag_t coef_mag(coef_t v);
        logic signed [MAG_W-1:0] e;
        e = MAG_W'(v);
        return e[MAG_W-1] ? mag_t'(-e) : mag_t'(e);
    endfunction

    function automatic prng_t lfsr_next(prng_t s);
        return {s[PRNG_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    // v * (1 + a*x) in fixed point, saturated to the coefficient range
    function automatic coef_t apply_mark(coef_t v, alpha_t a, prng_t x);
        logic signed [PROD_W-1:0] ev, ea, ex, p, d, s, hi, lo;
        ev = PROD_W'(v);
        ea = PROD_W'({1'b0, a});
        ex = PROD_W'($signed(x));
        p  = ev * ea * ex;
        d  = p >>> FRAC_W;
        s  = ev + d;
        hi = '0;
        hi[COEF_W-2:0] = '1;
        lo = '1;
        lo[COEF_W-2:0] = '0;
        if (s > hi)      return coef_t'(hi);
        else if (s < lo) return coef_t'(lo);
        else             return coef_t'(s);
    endfunction
endpackage

// File: rtl/dme_sel_track.sv
module dme_sel_track
    import dme_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                acc_i,
    input  idx_t                idx_i,
    input  coef_t               coef_i,
    output slot_t [TOP_N-1:0]   sel_o
);
    slot_t [TOP_N-1:0] slots;
    slot_t [TOP_N-1:0] ins;
    slot_t             cand;
    logic  [TOP_N-1:0] gt;

    always_comb begin
        cand.vld = 1'b1;
        cand.mag = coef_mag(coef_i);
        cand.idx = idx_i;
        for (int k = 0; k < TOP_N; k++) begin
            // strict compare keeps the earlier index on ties
            gt[k] = !slots[k].vld || (cand.mag > slots[k].mag);
        end
        ins[0] = gt[0] ? cand : slots[0];
        for (int k = 1; k < TOP_N; k++) begin
            if (!gt[k])        ins[k] = slots[k];
            else if (gt[k-1])  ins[k] = slots[k-1];
            else               ins[k] = cand;
        end
        sel_o = (acc_i && idx_i != '0) ? ins : slots;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slots <= '0;
        end else if (acc_i) begin
            if (idx_i == '0) slots <= '0;
            else             slots <= ins;
        end
    end

    generate
        for (genvar k = 0; k < TOP_N; k++) begin : g_chk
            p_no_dc_r3: assert property (@(posedge clk) disable iff (rst)
                slots[k].vld |-> slots[k].idx != '0);
            if (k > 0) begin : g_ord
                p_rank_order_r4: assert property (@(posedge clk) disable iff (rst)
                    slots[k].vld |-> (slots[k-1].vld && slots[k-1].mag >= slots[k].mag));
            end
        end
    endgenerate
endmodule

// File: rtl/dme_prng.sv
module dme_prng
    import dme_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  prng_t               seed_i,
    input  logic                adv_i,
    output prng_t [TOP_N-1:0]   xs_o
);
    prng_t state;
    prng_t walk;
    prng_t nxt_state;

    always_comb begin
        walk = state;
        for (int k = 0; k < TOP_N; k++) begin
            xs_o[k] = walk;
            walk    = lfsr_next(walk);
        end
        nxt_state = walk;
    end

    always_ff @(posedge clk) begin
        if (rst)        state <= (seed_i == '0) ? prng_t'(1) : seed_i;
        else if (adv_i) state <= nxt_state;
    end

    p_state_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        state != '0);
endmodule

// File: rtl/dme_pingpong.sv
module dme_pingpong
    import dme_pkg::*;
(
    input  logic   clk,
    input  logic   wr_en_i,
    input  logic   wr_bank_i,
    input  idx_t   wr_idx_i,
    input  coef_t  wr_data_i,
    input  logic   rd_bank_i,
    input  idx_t   rd_idx_i,
    output coef_t  rd_data_o
);
    coef_t mem [2][BLK_LEN];

    always_ff @(posedge clk) begin
        if (wr_en_i) mem[wr_bank_i][wr_idx_i] <= wr_data_i;
    end

    assign rd_data_o = mem[rd_bank_i][rd_idx_i];
endmodule

// File: rtl/dme_modulator.sv
module dme_modulator
    import dme_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                start_bank_i,
    input  alpha_t              start_alpha_i,
    input  mark_t [TOP_N-1:0]   start_sel_i,
    input  coef_t               rd_data_i,
    output logic                rd_bank_o,
    output idx_t                rd_idx_o,
    output logic                vld_o,
    output logic                sob_o,
    output coef_t               coef_o
);
    logic              active;
    idx_t              rcnt;
    logic              rbank;
    alpha_t            alpha_q;
    mark_t [TOP_N-1:0] sel_q;
    logic              hit;
    prng_t             hx;

    assign rd_bank_o = rbank;
    assign rd_idx_o  = rcnt;

    always_comb begin
        hit = 1'b0;
        hx  = '0;
        for (int k = 0; k < TOP_N; k++) begin
            if (sel_q[k].idx == rcnt) begin
                hit = 1'b1;
                hx  = sel_q[k].x;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            rcnt    <= '0;
            rbank   <= 1'b0;
            alpha_q <= '0;
            sel_q   <= '0;
            vld_o   <= 1'b0;
            sob_o   <= 1'b0;
            coef_o  <= '0;
        end else begin
            // output of the current index, even when a new block starts now
            vld_o  <= active;
            sob_o  <= active && (rcnt == '0);
            coef_o <= !active ? '0 : (hit ? apply_mark(rd_data_i, alpha_q, hx) : rd_data_i);
            if (start_i) begin
                active  <= 1'b1;
                rcnt    <= '0;
                rbank   <= start_bank_i;
                alpha_q <= start_alpha_i;
                sel_q   <= start_sel_i;
            end else if (active) begin
                if (rcnt == LAST_IDX) active <= 1'b0;
                rcnt <= rcnt + 1'b1;
            end
        end
    end

    p_replay_steps_r6: assert property (@(posedge clk) disable iff (rst)
        (active && rcnt != LAST_IDX && !start_i) |=> (active && rcnt == $past(rcnt) + 1'b1));
    p_replay_ends_r6: assert property (@(posedge clk) disable iff (rst)
        (active && rcnt == LAST_IDX && !start_i) |=> !active);
endmodule

// File: rtl/dct_mark_embed.sv
module dct_mark_embed
    import dme_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] wm_seed_i,
    input  logic [7:0]  wm_alpha_i,
    input  logic        coef_vld_i,
    input  logic        blk_start_i,
    input  logic [15:0] coef_i,
    output logic        coef_vld_o,
    output logic        blk_start_o,
    output logic [15:0] coef_o
);
    logic              in_blk;
    idx_t              cnt;
    logic              wbank;
    logic              acc;
    idx_t              cur_idx;
    logic              done;
    slot_t [TOP_N-1:0] sel;
    prng_t [TOP_N-1:0] xs;
    mark_t [TOP_N-1:0] marks;
    coef_t             rd_data;
    logic              rd_bank;
    idx_t              rd_idx;
    coef_t             out_c;

    assign acc     = coef_vld_i && (blk_start_i || in_blk);
    assign cur_idx = blk_start_i ? '0 : cnt;
    assign done    = acc && (cur_idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_blk <= 1'b0;
            cnt    <= '0;
            wbank  <= 1'b0;
        end else if (acc) begin
            if (done) begin
                in_blk <= 1'b0;
                cnt    <= '0;
                wbank  <= ~wbank;
            end else begin
                in_blk <= 1'b1;
                cnt    <= cur_idx + 1'b1;
            end
        end
    end

    generate
        for (genvar k = 0; k < TOP_N; k++) begin : g_mark
            assign marks[k].idx = sel[k].idx;
            assign marks[k].x   = xs[k];
        end
    endgenerate

    dme_sel_track u_sel (
        .clk    (clk),
        .rst    (rst),
        .acc_i  (acc),
        .idx_i  (cur_idx),
        .coef_i (coef_t'(coef_i)),
        .sel_o  (sel)
    );

    dme_prng u_prng (
        .clk    (clk),
        .rst    (rst),
        .seed_i (wm_seed_i),
        .adv_i  (done),
        .xs_o   (xs)
    );

    dme_pingpong u_buf (
        .clk       (clk),
        .wr_en_i   (acc),
        .wr_bank_i (wbank),
        .wr_idx_i  (cur_idx),
        .wr_data_i (coef_t'(coef_i)),
        .rd_bank_i (rd_bank),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data)
    );

    dme_modulator u_mod (
        .clk           (clk),
        .rst           (rst),
        .start_i       (done),
        .start_bank_i  (wbank),
        .start_alpha_i (wm_alpha_i),
        .start_sel_i   (marks),
        .rd_data_i     (rd_data),
        .rd_bank_o     (rd_bank),
        .rd_idx_o      (rd_idx),
        .vld_o         (coef_vld_o),
        .sob_o         (blk_start_o),
        .coef_o        (out_c)
    );

    assign coef_o = out_c;

    p_sob_needs_vld_r6: assert property (@(posedge clk) disable iff (rst)
        blk_start_o |-> coef_vld_o);
    p_run_contiguous_r6: assert property (@(posedge clk) disable iff (rst)
        (coef_vld_o && !blk_start_o) |-> $past(coef_vld_o));
    p_quiet_in_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (!coef_vld_o && coef_o == '0));
endmodule

// File: tb/tb_dct_mark_embed.sv
module tb_dct_mark_embed;
    typedef struct {
        logic        sob;
        logic [15:0] v;
        int          req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] wm_seed_i = 16'h1D2B;
    logic [7:0]  wm_alpha_i = 8'd0;
    logic        coef_vld_i = 1'b0;
    logic        blk_start_i = 1'b0;
    logic [15:0] coef_i = 16'd0;
    logic        coef_vld_o;
    logic        blk_start_o;
    logic [15:0] coef_o;

    int total = 0;
    int bad = 0;
    int out_count = 0;
    int run_len = 0;
    int max_run = 0;
    string phase = "R1";
    item_t sb[$];
    logic [15:0] model_state;
    logic signed [15:0] pat [64];

    always #5 clk = ~clk;

    dct_mark_embed dut (
        .clk(clk), .rst(rst), .wm_seed_i(wm_seed_i), .wm_alpha_i(wm_alpha_i),
        .coef_vld_i(coef_vld_i), .blk_start_i(blk_start_i), .coef_i(coef_i),
        .coef_vld_o(coef_vld_o), .blk_start_o(blk_start_o), .coef_o(coef_o)
    );

    function automatic string tag_of(int r);
        case (r)
            3: return "R3";
            5: return "R5";
            7: return "R4 R7";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // R8 reference stepping
    function automatic logic [15:0] step(logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    // R7 reference arithmetic
    function automatic logic [15:0] mark_ref(int v, int a, logic [15:0] x);
        longint p, d, s;
        p = longint'(v) * longint'(a) * longint'($signed(x));
        d = p >>> 23;
        s = longint'(v) + d;
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return 16'(s);
    endfunction

    function automatic int mag(int v);
        return (v < 0) ? -v : v;
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && coef_vld_o) begin
            out_count++;
            run_len++;
            if (run_len > max_run) max_run = run_len;
            if (sb.size() == 0) begin
                check(1'b0, "R2", "unexpected output", int'($signed(coef_o)), 0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(coef_o == it.v, tag_of(it.req), {"coef ", phase},
                      int'($signed(coef_o)), int'($signed(it.v)));
                check(blk_start_o == it.sob, "R6", {"start marker ", phase},
                      int'(blk_start_o), int'(it.sob));
            end
        end else begin
            run_len = 0;
        end
    end

    task automatic do_reset(input logic [15:0] s);
        @(negedge clk);
        rst = 1'b1;
        wm_seed_i = s;
        coef_vld_i = 1'b0;
        blk_start_i = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_state = (s == 16'd0) ? 16'd1 : s;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            coef_vld_i = 1'b0;
            blk_start_i = 1'b0;
        end
    endtask

    // drive pat[] as one block, pushing expectations first
    task automatic send_block(input int a, input bit chk_timing);
        int sel [3];
        logic [15:0] xr [3];
        for (int r = 0; r < 3; r++) begin
            int best;
            best = -1;
            for (int i = 1; i < 64; i++) begin
                bit used;
                used = 1'b0;
                for (int q = 0; q < r; q++) if (sel[q] == i) used = 1'b1;
                if (!used && (best < 0 || mag(int'(pat[i])) > mag(int'(pat[best])))) best = i;
            end
            sel[r] = best;
            xr[r] = model_state;
            model_state = step(model_state);
        end
        for (int i = 0; i < 64; i++) begin
            item_t it;
            it.sob = (i == 0);
            it.v   = pat[i];
            it.req = (i == 0) ? 3 : 5;
            for (int r = 0; r < 3; r++) begin
                if (sel[r] == i) begin
                    it.v = mark_ref(int'(pat[i]), a, xr[r]);
                    it.req = 7;
                end
            end
            sb.push_back(it);
        end
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            coef_vld_i = 1'b1;
            blk_start_i = (i == 0);
            coef_i = pat[i];
            wm_alpha_i = 8'(a);
        end
        if (chk_timing) begin
            @(negedge clk);
            coef_vld_i = 1'b0;
            blk_start_i = 1'b0;
            check(coef_vld_o == 1'b0, "R6", "valid one cycle early", int'(coef_vld_o), 0);
            @(negedge clk);
            check(coef_vld_o == 1'b1 && blk_start_o == 1'b1, "R6", "first output cycle",
                  int'({coef_vld_o, blk_start_o}), 3);
        end
    endtask

    task automatic drain();
        int guard;
        guard = 0;
        while (sb.size() != 0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        idle(4);
        check(sb.size() == 0, "R6", "outputs missing", sb.size(), 0);
    endtask

    task automatic pat_ramp();
        for (int i = 0; i < 64; i++) pat[i] = 16'(((i * 29) % 64) * 50 - 1600);
    endtask
    task automatic pat_tie();
        pat[0] = 16'sd500;
        for (int i = 1; i < 64; i++) pat[i] = (i % 2 == 1) ? 16'sd100 : -16'sd100;
    endtask
    task automatic pat_sat();
        pat[0] = 16'sd0;
        for (int i = 1; i < 64; i++) pat[i] = 16'sd10;
        pat[5] = -16'sd32768; pat[9] = 16'sd32767; pat[20] = -16'sd32768; pat[40] = -16'sd32768;
    endtask
    task automatic pat_dc();
        pat[0] = 16'sd32767;
        for (int i = 1; i < 64; i++) pat[i] = 16'((i * 7) % 23 - 11);
    endtask

    initial begin
        int c0;
        model_state = 16'h1D2B;
        do_reset(16'h1D2B);
        // R1: quiet after reset
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(coef_vld_o == 1'b0 && blk_start_o == 1'b0 && coef_o == 16'd0, "R1",
                  "outputs after reset", int'(coef_o), 0);
        end
        // R2: valid data with no block started is ignored
        phase = "R2";
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            coef_vld_i = 1'b1; blk_start_i = 1'b0; coef_i = 16'(i + 7);
        end
        idle(80);
        check(out_count == 0, "R2", "stray input produced output", out_count, 0);
        // R6: first block, timing checked; R4 R7 via scoreboard
        phase = "R6";
        pat_ramp();
        send_block(64, 1'b1);
        drain();
        // R2: abandoned partial block, then a full one, then stray data
        phase = "R2";
        c0 = out_count;
        pat_ramp();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            coef_vld_i = 1'b1; blk_start_i = (i == 0); coef_i = pat[i];
        end
        idle(3);
        pat_tie();                      // R4 tie break: indices 1,2,3
        send_block(255, 1'b0);
        idle(1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            coef_vld_i = 1'b1; blk_start_i = 1'b0; coef_i = 16'sd9000;
        end
        idle(1);
        drain();
        idle(70);
        check(out_count - c0 == 64, "R2", "output count after partial+stray", out_count - c0, 64);
        // R7: saturation
        phase = "R7";
        pat_sat();
        send_block(255, 1'b0);
        drain();
        // R3: large DC stays untouched
        phase = "R3";
        pat_dc();
        send_block(200, 1'b0);
        drain();
        // R5: zero strength passes everything
        phase = "R5";
        pat_ramp();
        send_block(0, 1'b0);
        drain();
        // R9: back-to-back blocks, handoff coincides with last output
        phase = "R9";
        max_run = 0;
        pat_ramp(); send_block(17, 1'b0);
        pat_sat();  send_block(128, 1'b0);
        pat_tie();  send_block(3, 1'b0);
        idle(1);
        drain();
        check(max_run >= 192, "R9", "longest output run", max_run, 192);
        // R8: repeatable after reseed, and zero seed
        phase = "R8";
        do_reset(16'hACE1);
        pat_ramp(); send_block(90, 1'b0);
        drain();
        do_reset(16'hACE1);
        pat_ramp(); send_block(90, 1'b0);
        pat_dc();   send_block(250, 1'b0);
        idle(1);
        drain();
        do_reset(16'h0000);
        pat_tie(); send_block(180, 1'b0);
        idle(1);
        drain();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule